// File: doc/BRIEF.md
# Bus Fault Guard with Abort Status Capture

This unit sits beside a 32-bit internal bus shared by two masters. It looks at every access as it is presented. An access is refused when its address is not aligned to its size, or when the address decoder reports no hit. A refused access raises a single abort line that all masters see, whichever master made the access, and a cancel line that stops the access going further. Both lines are combinational and assert in the same cycle as the access. Instruction fetches skip the alignment test but are still refused when unmapped.

On every refused access the unit records the full faulting address and a status word. The status word holds the access size, the access kind, one flag for each fault cause, a one-hot field naming the master behind the latest fault, and one sticky flag per master. A master's sticky flag shows that its earlier fault record was overwritten by a fault from another master. Both records are read through a small registered read port. Reading the status word clears the sticky flags.

Top module: `bus_fault_guard`

## Requirements
- R1: A valid word access (size 2'b10) whose address bits [1:0] are not 00, with a kind other than fetch, drives abort_o and cancel_o high in the same cycle.
- R2: A valid half-word access (size 2'b01) with address bit 0 set, with a kind other than fetch, aborts and cancels in the same cycle. A half-word at an even address with a decode hit does not abort.
- R3: Byte accesses (size 2'b00) never abort on alignment. Fetches (kind 2'b10) never abort on alignment.
- R4: A valid access with acc_hit low aborts and cancels. When such an access is also misaligned, both fault flags are recorded.
- R5: With acc_valid low, abort_o and cancel_o stay low and no record changes.
- R6: On the clock edge that ends an aborted access, the address record takes the full 32-bit acc_addr. Without an abort, the address record holds its value.
- R7: Status word layout, updated on an abort: bits [1:0] are the size, bits [3:2] are the kind (00 read, 01 write, 10 fetch), bit 4 is the unmapped flag and bit 5 is the misaligned flag.
- R8: Status bits [9:8] are one-hot and name the master of the latest abort: bit 8 is master 0 and bit 9 is master 1.
- R9: Status bits [17:16] are the sticky flags for masters 0 and 1. A master's flag is set when its fault is held in the last-source bits and a master other than it then aborts. A repeated abort by the same master sets no flag.
- R10: A read with rd_sel=1 returns the status word. A read with rd_sel=0 returns the address record. Data is returned on rd_data with rd_valid high one cycle after rd_en. A status read clears the sticky flags and an address read leaves them unchanged.
- R11: After a synchronous reset, both records read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_addr | input | 32 | Access address |
| acc_size | input | 2 | 00 byte, 01 half-word, 10 word |
| acc_kind | input | 2 | 00 data read, 01 data write, 10 code fetch |
| acc_master | input | 1 | Issuing master ID |
| acc_hit | input | 1 | Address decoder found a mapped region |
| abort_o | output | 1 | Abort sent to all masters |
| cancel_o | output | 1 | Cancels the current access |
| rd_en | input | 1 | Record read request |
| rd_sel | input | 1 | 0 address record, 1 status word |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | rd_data is valid this cycle |

## Verification
The alignment check is tried at every size with aligned and unaligned offsets. This separates the word rule from the half-word rule and shows that bytes and fetches are exempt. Unmapped accesses are applied both on their own and combined with misalignment, to show that each cause sets only its own flag. A sequence of faults that alternates between masters and then repeats one master separates the overwrite rule for the sticky flags from a plain per-master fault flag. Address reads placed between status reads show that only status reads clear the sticky flags.

// File: rtl/bfg_pkg.sv
package bfg_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } size_e;

  typedef enum logic [1:0] {
    K_READ  = 2'b00,
    K_WRITE = 2'b01,
    K_FETCH = 2'b10
  } kind_e;

  typedef struct packed {
    logic [1:0] size;
    logic [1:0] kind;
    logic       unmapped;
    logic       misaligned;
  } fault_rec_t;

  localparam int ST_UNM_BIT = 4;
  localparam int ST_MIS_BIT = 5;
  localparam int ST_SRC_LSB = 8;
  localparam int ST_STK_LSB = 16;
endpackage

// File: rtl/bfg_check.sv
module bfg_check
  import bfg_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] addr_lo,
  input  logic [1:0] size,
  input  logic [1:0] kind,
  input  logic       hit,
  output logic       misalign,
  output logic       unmapped,
  output logic       fault
);
  logic bad_word;
  logic bad_half;
  logic exempt;

  always_comb begin
    exempt   = (kind == K_FETCH);
    bad_word = (size == SZ_WORD) && (addr_lo != 2'b00);
    bad_half = (size == SZ_HALF) && addr_lo[0];
    misalign = valid && !exempt && (bad_word || bad_half);
    unmapped = valid && !hit;
    fault    = misalign || unmapped;
  end
endmodule

// File: rtl/bfg_capture.sv
module bfg_capture
  import bfg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NMST   = 2,
  localparam int MID_W = (NMST > 1) ? $clog2(NMST) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fault,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [1:0]        kind,
  input  logic              misalign,
  input  logic              unmapped,
  input  logic [MID_W-1:0]  master,
  input  logic              clr_sticky,
  output logic [ADDR_W-1:0] fault_addr_q,
  output fault_rec_t        rec_q,
  output logic [NMST-1:0]   last_src_q,
  output logic [NMST-1:0]   sticky_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fault_addr_q <= '0;
      rec_q        <= '0;
    end else if (fault) begin
      fault_addr_q     <= addr;
      rec_q.size       <= size;
      rec_q.kind       <= kind;
      rec_q.unmapped   <= unmapped;
      rec_q.misaligned <= misalign;
    end
  end

  for (genvar m = 0; m < NMST; m++) begin : g_mst
    logic from_me;
    logic displaced;
    assign from_me   = fault && (master == MID_W'(m));
    assign displaced = fault && last_src_q[m] && !from_me;

    always_ff @(posedge clk) begin
      if (rst) begin
        last_src_q[m] <= 1'b0;
        sticky_q[m]   <= 1'b0;
      end else begin
        if (fault) last_src_q[m] <= from_me;
        if (displaced)       sticky_q[m] <= 1'b1;
        else if (clr_sticky) sticky_q[m] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bfg_readout.sv
module bfg_readout
  import bfg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NMST   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic [ADDR_W-1:0] fault_addr_q,
  input  fault_rec_t        rec_q,
  input  logic [NMST-1:0]   last_src_q,
  input  logic [NMST-1:0]   sticky_q,
  output logic              clr_sticky,
  output logic [ADDR_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [ADDR_W-1:0] status_word;

  always_comb begin
    status_word                         = '0;
    status_word[1:0]                    = rec_q.size;
    status_word[3:2]                    = rec_q.kind;
    status_word[ST_UNM_BIT]             = rec_q.unmapped;
    status_word[ST_MIS_BIT]             = rec_q.misaligned;
    status_word[ST_SRC_LSB +: NMST]     = last_src_q;
    status_word[ST_STK_LSB +: NMST]     = sticky_q;
    clr_sticky                          = rd_en && rd_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_sel ? status_word : fault_addr_q;
    end
  end
endmodule

// File: rtl/bus_fault_guard.sv
module bus_fault_guard
  import bfg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NMST   = 2,
  localparam int MID_W = (NMST > 1) ? $clog2(NMST) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [1:0]        acc_kind,
  input  logic [MID_W-1:0]  acc_master,
  input  logic              acc_hit,
  output logic              abort_o,
  output logic              cancel_o,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [ADDR_W-1:0] rd_data,
  output logic              rd_valid
);
  logic              misalign;
  logic              unmapped;
  logic              fault;
  logic              clr_sticky;
  logic [ADDR_W-1:0] fault_addr_q;
  fault_rec_t        rec_q;
  logic [NMST-1:0]   last_src_q;
  logic [NMST-1:0]   sticky_q;

  bfg_check u_check (
    .valid    (acc_valid),
    .addr_lo  (acc_addr[1:0]),
    .size     (acc_size),
    .kind     (acc_kind),
    .hit      (acc_hit),
    .misalign (misalign),
    .unmapped (unmapped),
    .fault    (fault)
  );

  bfg_capture #(.ADDR_W(ADDR_W), .NMST(NMST)) u_capture (
    .clk          (clk),
    .rst          (rst),
    .fault        (fault),
    .addr         (acc_addr),
    .size         (acc_size),
    .kind         (acc_kind),
    .misalign     (misalign),
    .unmapped     (unmapped),
    .master       (acc_master),
    .clr_sticky   (clr_sticky),
    .fault_addr_q (fault_addr_q),
    .rec_q        (rec_q),
    .last_src_q   (last_src_q),
    .sticky_q     (sticky_q)
  );

  bfg_readout #(.ADDR_W(ADDR_W), .NMST(NMST)) u_readout (
    .clk          (clk),
    .rst          (rst),
    .rd_en        (rd_en),
    .rd_sel       (rd_sel),
    .fault_addr_q (fault_addr_q),
    .rec_q        (rec_q),
    .last_src_q   (last_src_q),
    .sticky_q     (sticky_q),
    .clr_sticky   (clr_sticky),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid)
  );

  assign abort_o  = fault;
  assign cancel_o = fault;
endmodule

// File: rtl/bfg_assert.sv
module bfg_assert #(
  parameter int ADDR_W = 32,
  parameter int NMST   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        acc_size,
  input logic [1:0]        acc_kind,
  input logic              acc_hit,
  input logic              abort_o,
  input logic              cancel_o,
  input logic              rd_en,
  input logic              rd_sel,
  input logic [ADDR_W-1:0] fault_addr_q,
  input logic [NMST-1:0]   last_src_q,
  input logic [NMST-1:0]   sticky_q
);
  a_r1_word_misalign: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_size == 2'b10 && acc_addr[1:0] != 2'b00 && acc_kind != 2'b10)
      |-> (abort_o && cancel_o));

  a_r2_half_misalign: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_size == 2'b01 && acc_addr[0] && acc_kind != 2'b10)
      |-> (abort_o && cancel_o));

  a_r3_fetch_exempt: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_hit && (acc_kind == 2'b10 || acc_size == 2'b00)) |-> !abort_o);

  a_r4_unmapped: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_hit) |-> (abort_o && cancel_o));

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |-> (!abort_o && !cancel_o));

  a_r6_addr_capture: assert property (@(posedge clk) disable iff (rst)
    abort_o |=> (fault_addr_q == $past(acc_addr)));

  a_r6_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !abort_o |=> $stable(fault_addr_q));

  a_r8_src_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(last_src_q));

  a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel && !abort_o) |=> (sticky_q == '0));
endmodule

bind bus_fault_guard bfg_assert #(.ADDR_W(ADDR_W), .NMST(NMST)) u_bfg_assert (
  .clk          (clk),
  .rst          (rst),
  .acc_valid    (acc_valid),
  .acc_addr     (acc_addr),
  .acc_size     (acc_size),
  .acc_kind     (acc_kind),
  .acc_hit      (acc_hit),
  .abort_o      (abort_o),
  .cancel_o     (cancel_o),
  .rd_en        (rd_en),
  .rd_sel       (rd_sel),
  .fault_addr_q (fault_addr_q),
  .last_src_q   (last_src_q),
  .sticky_q     (sticky_q)
);

// File: tb/bus_fault_guard_test.sv
module bus_fault_guard_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [1:0]  acc_kind = '0;
  logic [0:0]  acc_master = '0;
  logic        acc_hit = 1'b1;
  logic        abort_o, cancel_o;
  logic        rd_en = 1'b0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  // bench model of the records, built from the requirements
  logic [31:0] m_addr = '0;
  logic [1:0]  m_size = '0, m_kind = '0, m_src = '0, m_stk = '0;
  logic        m_unm = 0, m_mis = 0;

  always #5 clk = ~clk;

  bus_fault_guard uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_kind(acc_kind), .acc_master(acc_master),
    .acc_hit(acc_hit), .abort_o(abort_o), .cancel_o(cancel_o),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [31:0] model_status();
    logic [31:0] s = '0;
    s[1:0]   = m_size;
    s[3:2]   = m_kind;
    s[4]     = m_unm;
    s[5]     = m_mis;
    s[9:8]   = m_src;
    s[17:16] = m_stk;
    return s;
  endfunction

  task automatic compare(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(logic [31:0] a, logic [1:0] sz, logic [1:0] k,
                        logic mst, logic hit, logic vld, string tag);
    logic mis, unm, ab;
    mis = vld && (k != 2'b10) &&
          ((sz == 2'b10 && a[1:0] != 2'b00) || (sz == 2'b01 && a[0]));
    unm = vld && !hit;
    ab  = mis || unm;
    @(negedge clk);
    acc_valid = vld; acc_addr = a; acc_size = sz; acc_kind = k;
    acc_master = mst; acc_hit = hit;
    #1;
    compare({tag, " abort"}, {31'b0, abort_o}, {31'b0, ab});
    compare({tag, " cancel"}, {31'b0, cancel_o}, {31'b0, ab});
    if (ab) begin
      m_addr = a; m_size = sz; m_kind = k; m_unm = unm; m_mis = mis;
      for (int m = 0; m < 2; m++)
        if (m_src[m] && (m != int'(mst))) m_stk[m] = 1'b1;
      m_src = mst ? 2'b10 : 2'b01;
    end
    @(posedge clk); #1;
    acc_valid = 1'b0;
  endtask

  task automatic read_rec(logic sel, string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    exp_q.push_back(sel ? model_status() : m_addr);
    tag_q.push_back(tag);
    if (sel) m_stk = '0;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  // monitor: pops expected items as read data appears
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10: unexpected read data actual %h expected none", rd_data);
      end else begin
        compare(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    read_rec(1'b0, "R11 address after reset");
    read_rec(1'b1, "R11 status after reset");
    access(32'h0000_1000, 2'b10, 2'b00, 1'b0, 1'b1, 1'b1, "R1 aligned word");
    access(32'h0000_1002, 2'b10, 2'b00, 1'b0, 1'b1, 1'b1, "R1 word offset 2");
    read_rec(1'b0, "R6 captured address");
    read_rec(1'b1, "R7 R8 status after word fault");
    access(32'h0000_2001, 2'b01, 2'b01, 1'b1, 1'b1, 1'b1, "R2 odd half-word");
    access(32'h0000_2002, 2'b01, 2'b01, 1'b1, 1'b1, 1'b1, "R2 even half-word");
    access(32'h0000_3003, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, "R3 odd byte");
    access(32'h0000_4003, 2'b10, 2'b10, 1'b0, 1'b1, 1'b1, "R3 unaligned fetch");
    read_rec(1'b0, "R6 address held");
    read_rec(1'b1, "R9 sticky on displaced master");
    read_rec(1'b1, "R10 sticky cleared by status read");
    access(32'h0000_5000, 2'b10, 2'b10, 1'b1, 1'b0, 1'b1, "R4 unmapped fetch");
    read_rec(1'b1, "R9 repeat master no sticky");
    access(32'h0000_6001, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, "R4 misaligned and unmapped");
    read_rec(1'b0, "R10 address read");
    read_rec(1'b1, "R4 R9 both flags and sticky kept");
    read_rec(1'b1, "R10 sticky cleared");
    access(32'h0000_7003, 2'b10, 2'b00, 1'b1, 1'b0, 1'b0, "R5 idle bad inputs");
    read_rec(1'b0, "R5 address unchanged");
    read_rec(1'b1, "R5 status unchanged");
    repeat (3) @(negedge clk);
    compare("R10 all reads returned", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule